// File: doc/BRIEF.md
# I2C Bus Condition Controller

This block is the master-side condition engine of an I2C controller. It watches the synchronized SDA and SCL lines and keeps a bus-busy flag. The flag goes up when it sees a START and down when it sees a STOP. On request from a single 8-bit control register it drives the open-drain enables of both lines. This lets it place a START, a repeated START or a STOP on the bus. Byte shifting, acknowledge, addressing and arbitration belong to other blocks.

Software writes the control register with the busy bit holding the wanted direction (1 = START, 0 = STOP) and the gate bit at 0. A write with the gate bit at 1 changes nothing. Reading the register returns the bus-busy flag, the constant gate bit and the present output levels of both lines. Condition timing comes from an external prescaler tick. Every phase of a generated condition lasts `PHASE_TICKS` ticks. While a condition is being generated, `cond_pending_o` is high.

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset the register reads 8'h7C, both line enables are 0 (released) and `cond_pending_o` is 0.
- R2: A falling SDA while SCL is high sets the busy flag, bit 7 of the register.
- R3: A rising SDA while SCL is high clears the busy flag.
- R4: SDA edges while SCL is low leave the busy flag unchanged.
- R5: A write with bit 7 = 1 and bit 6 = 0 on a released bus raises the SDA enable `PHASE_TICKS` ticks after the write edge. It raises the SCL enable `PHASE_TICKS` ticks after that. The pending output is high over that whole span.
- R6: A write with bit 7 = 0 and bit 6 = 0 on a held bus goes through three phases of `PHASE_TICKS` ticks each: SCL low, then SDA low, then SCL released. After the third phase SDA is released. This releases SCL 2 phases after the write edge and SDA 3 phases after it, and it clears the busy flag.
- R7: A START write on a held bus first releases SDA with SCL low. One phase later it releases SCL, one phase after that it pulls SDA low, and one phase after that it pulls SCL low. The busy flag stays 1 throughout, and the two enables never change in the same cycle.
- R8: A write with bit 6 = 1 starts no condition and leaves bit 7 unchanged. Bit 6 always reads 1.
- R9: Bit 5 reads the SDA output level (1 = released) and bit 3 reads the SCL output level. Bits 4 and 2 read 1, and bits 1:0 read 0.
- R10: START and STOP writes that arrive while a condition is pending are ignored. This includes a write in the very cycle the condition completes.
- R11: A generated condition advances only on cycles where `tick_i` is high. Without ticks, both enables and the pending output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler tick, paces condition phases |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| sda_i | input | 1 | SDA line level |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| cond_pending_o | output | 1 | Generated condition in progress |

## Verification
Two functions can meet in one cycle: accepting a new condition write, and finishing the condition already in progress. The bench provokes this by timing a STOP write onto the exact edge where a repeated START leaves its last phase. It then confirms that both lines stay held low and the busy flag stays set, which shows the write was dropped. A second overlap happens between generation and detection, because the block observes its own lines. The bench checks that a repeated START never shows a STOP to the busy tracker.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int unsigned BIT_BUSY = 7;
  localparam int unsigned BIT_GATE = 6;
  localparam int unsigned BIT_SDA  = 5;
  localparam int unsigned BIT_SCL  = 3;

  typedef enum logic [1:0] {REQ_NONE, REQ_START, REQ_STOP} cond_req_e;

  typedef enum logic [2:0] {
    G_IDLE,
    G_RS_REL,    // repeated start: release SDA, SCL low
    G_ST_SETUP,  // both released
    G_ST_HOLD,   // SDA low, SCL released
    G_SP_SCL,    // SCL low
    G_SP_SDA,    // SDA low, SCL low
    G_SP_SETUP   // SDA low, SCL released
  } gen_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_s_o,
  output logic scl_s_o,
  output logic sda_prev_o
);
  logic [STAGES-1:0] sda_ff, scl_ff;
  logic              sda_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_ff[0] <= 1'b1;
      scl_ff[0] <= 1'b1;
    end else begin
      sda_ff[0] <= sda_i;
      scl_ff[0] <= scl_i;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sda_ff[i] <= 1'b1;
        scl_ff[i] <= 1'b1;
      end else begin
        sda_ff[i] <= sda_ff[i-1];
        scl_ff[i] <= scl_ff[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_prev_q <= 1'b1;
    else         sda_prev_q <= sda_ff[STAGES-1];
  end

  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_prev_o = sda_prev_q;
endmodule

// File: rtl/i2c_busy_track.sv
module i2c_busy_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic sda_prev_i,
  output logic busy_o
);
  logic busy_q, start_seen, stop_seen;

  assign start_seen = scl_s_i &  sda_prev_i & ~sda_s_i;
  assign stop_seen  = scl_s_i & ~sda_prev_i &  sda_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         busy_q <= 1'b0;
    else if (start_seen) busy_q <= 1'b1;
    else if (stop_seen)  busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  a_r2_set_needs_scl_high_sda_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(scl_s_i && !sda_s_i));
  a_r3_clr_needs_scl_high_sda_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> $past(scl_s_i && sda_s_i));
endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
  import i2c_cond_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  cond_req_e req_i,
  output logic      sda_oe_o,
  output logic      scl_oe_o,
  output logic      pending_o
);
  localparam int unsigned CW = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_TICKS - 1);

  gen_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          sda_oe_q, sda_oe_d, scl_oe_q, scl_oe_d, phase_done;

  assign phase_done = tick_i && (cnt_q == LAST);

  always_comb begin
    st_d     = st_q;
    sda_oe_d = sda_oe_q;
    scl_oe_d = scl_oe_q;
    unique case (st_q)
      G_IDLE: begin
        if (req_i == REQ_START) begin
          if (scl_oe_q) begin
            st_d     = G_RS_REL;
            sda_oe_d = 1'b0;
          end else begin
            st_d = G_ST_SETUP;
          end
        end else if (req_i == REQ_STOP) begin
          st_d     = G_SP_SCL;
          scl_oe_d = 1'b1;
        end
      end
      G_RS_REL:   if (phase_done) begin st_d = G_ST_SETUP; scl_oe_d = 1'b0; end
      G_ST_SETUP: if (phase_done) begin st_d = G_ST_HOLD;  sda_oe_d = 1'b1; end
      G_ST_HOLD:  if (phase_done) begin st_d = G_IDLE;     scl_oe_d = 1'b1; end
      G_SP_SCL:   if (phase_done) begin st_d = G_SP_SDA;   sda_oe_d = 1'b1; end
      G_SP_SDA:   if (phase_done) begin st_d = G_SP_SETUP; scl_oe_d = 1'b0; end
      G_SP_SETUP: if (phase_done) begin st_d = G_IDLE;     sda_oe_d = 1'b0; end
      default:    st_d = G_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= G_IDLE;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      sda_oe_q <= sda_oe_d;
      scl_oe_q <= scl_oe_d;
      if (st_d != st_q)  cnt_q <= '0;
      else if (tick_i)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = scl_oe_q;
  assign pending_o = (st_q != G_IDLE);

  a_r7_no_joint_line_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!$stable(sda_oe_q) && !$stable(scl_oe_q)));
  a_r11_no_tick_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != G_IDLE && !tick_i) |=> $stable(st_q) && $stable(sda_oe_q) && $stable(scl_oe_q));
endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
#(
  parameter int unsigned PHASE_TICKS = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       sda_i,
  input  logic       scl_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       cond_pending_o
);
  logic      sda_s, scl_s, sda_prev, bus_busy, pending, sda_oe, scl_oe;
  cond_req_e req;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sda_i, .scl_i,
    .sda_s_o(sda_s), .scl_s_o(scl_s), .sda_prev_o(sda_prev)
  );

  i2c_busy_track u_busy (
    .clk_i, .rst_ni, .sda_s_i(sda_s), .scl_s_i(scl_s),
    .sda_prev_i(sda_prev), .busy_o(bus_busy)
  );

  always_comb begin
    req = REQ_NONE;
    if (wr_en_i && !wr_data_i[BIT_GATE] && !pending)
      req = wr_data_i[BIT_BUSY] ? REQ_START : REQ_STOP;
  end

  i2c_cond_gen #(.PHASE_TICKS(PHASE_TICKS)) u_gen (
    .clk_i, .rst_ni, .tick_i, .req_i(req),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .pending_o(pending)
  );

  always_comb begin
    rd_data_o          = 8'h14;  // reserved bits 4 and 2
    rd_data_o[BIT_BUSY] = bus_busy;
    rd_data_o[BIT_GATE] = 1'b1;
    rd_data_o[BIT_SDA]  = ~sda_oe;
    rd_data_o[BIT_SCL]  = ~scl_oe;
  end

  assign sda_oe_o       = sda_oe;
  assign scl_oe_o       = scl_oe;
  assign cond_pending_o = pending;

  a_r8_gate_blocks_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[BIT_GATE] && !pending) |=> !pending);
  a_r9_gate_reads_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BIT_GATE] && rd_data_o[4] && rd_data_o[2]);
endmodule

// File: tb/i2c_cond_ctrl_test.sv
module i2c_cond_ctrl_test;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       ext_sda = 1'b1, ext_scl = 1'b1;
  logic       sda_oe, scl_oe, pending;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  i2c_cond_ctrl #(.PHASE_TICKS(N), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .sda_i(~sda_oe & ext_sda), .scl_i(~scl_oe & ext_scl),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .cond_pending_o(pending)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int max_k, output int ks, output int kc, output bit busy_lost);
    logic s0, c0;
    s0 = sda_oe; c0 = scl_oe; ks = -1; kc = -1; busy_lost = 0;
    for (int k = 1; k <= max_k; k++) begin
      @(negedge clk);
      if (ks < 0 && sda_oe !== s0) ks = k;
      if (kc < 0 && scl_oe !== c0) kc = k;
      if (!rd_data[7]) busy_lost = 1;
    end
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data, 8'h7C);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 pending", pending, 0);
    chk("R9 low bits", rd_data[1:0], 0);
  endtask

  task automatic t_ext;
    ext_sda = 1'b0; cyc(5);
    chk("R2 ext start", rd_data[7], 1);
    ext_scl = 1'b0; cyc(2); ext_sda = 1'b1; cyc(5);
    chk("R4 sda rise scl low", rd_data[7], 1);
    ext_scl = 1'b1; cyc(5);
    ext_sda = 1'b0; cyc(5);
    ext_sda = 1'b1; cyc(5);
    chk("R3 ext stop", rd_data[7], 0);
    ext_scl = 1'b0; cyc(2); ext_sda = 1'b0; cyc(5);
    chk("R4 sda fall scl low", rd_data[7], 0);
    ext_sda = 1'b1; cyc(2); ext_scl = 1'b1; cyc(5);
    chk("R4 restore", rd_data[7], 0);
  endtask

  task automatic t_gate;
    wr(8'hFC);
    chk("R8 no pending", pending, 0);
    cyc(10);
    chk("R8 lines", {sda_oe, scl_oe}, 2'b00);
    chk("R8 rd", rd_data, 8'h7C);
  endtask

  task automatic t_start;
    int ks, kc; bit bl;
    wr(8'hBC);
    chk("R5 pending", pending, 1);
    measure(2 * N + 2, ks, kc, bl);
    chk("R5 sda delay", ks, N);
    chk("R5 scl delay", kc, 2 * N);
    chk("R5 done", pending, 0);
    cyc(5);
    chk("R9 rd held", rd_data, 8'hD4);
  endtask

  task automatic t_rstart;
    int ks, kc; bit bl;
    wr(8'hBC);
    chk("R7 sda released", sda_oe, 0);
    chk("R7 scl held", scl_oe, 1);
    measure(N + 1, ks, kc, bl);
    chk("R7 scl release", kc, N);
    measure(2 * N + 2, ks, kc, bl);
    chk("R7 sda low", ks, N - 1);
    chk("R7 scl low", kc, 2 * N - 1);
    chk("R7 busy kept", bl, 0);
    cyc(5);
    chk("R7 rd", rd_data, 8'hD4);
  endtask

  task automatic t_collide;
    wr(8'hBC);
    cyc(3 * N - 1);
    chk("R10 still pending", pending, 1);
    wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 done", pending, 0);
    cyc(10);
    chk("R10 lines held", {sda_oe, scl_oe}, 2'b11);
    chk("R10 pending", pending, 0);
    chk("R10 busy", rd_data[7], 1);
  endtask

  task automatic t_stop;
    int ks, kc; bit bl;
    wr(8'h3C);
    chk("R6 pending", pending, 1);
    measure(3 * N + 2, ks, kc, bl);
    chk("R6 scl release", kc, 2 * N);
    chk("R6 sda release", ks, 3 * N);
    cyc(5);
    chk("R6 busy clear", rd_data[7], 0);
    chk("R6 rd", rd_data, 8'h7C);
  endtask

  task automatic t_tick;
    tick_en = 1'b0;
    wr(8'hBC);
    cyc(20);
    chk("R11 frozen pending", pending, 1);
    chk("R11 frozen lines", {sda_oe, scl_oe}, 2'b00);
    wr(8'h3C);
    tick_en = 1'b1;
    cyc(2 * N + 2);
    chk("R11 resumed", {sda_oe, scl_oe}, 2'b11);
    chk("R10 stop ignored", pending, 0);
    cyc(5);
    t_stop;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset;
    rst_n = 1'b1;
    cyc(3);
    t_reset;
    t_ext;
    t_gate;
    t_start;
    t_rstart;
    t_collide;
    t_stop;
    t_tick;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule